// File: doc/BRIEF.md
# Operand-Wakeup Issue Pool

This block holds a small number of instructions destined for one functional unit while they wait for their operands. Each instruction arrives with two sources. A source is either already known, and carries its value, or still pending, and carries the tag of the instruction that will produce it. The pool watches a result broadcast bus. When the tag on the bus matches a pending source, the entry takes the broadcast value and marks that source known.

An entry whose two sources are both known is ready. The pool offers one ready entry at a time to the functional unit. If several entries are ready, it offers the one that was allocated earliest. Program order has no other effect, so a younger independent instruction can leave ahead of an older one that is still waiting. The slot number of an entry, offset by a base value, is the tag under which its result will later be broadcast. The slot is released when its instruction is handed to the unit. The pool raises a full flag when every slot is occupied and refuses allocation while that flag is high.

Top module: `rs_issue_pool`

## Requirements
- R1: After reset, no slot is occupied, `disp_valid` and `full` are low, and `alloc_tag` equals `BASE_TAG`.
- R2: An instruction allocated with both sources known is offered in the cycle after the allocating clock edge. The offer shows its opcode, both operand values, and `disp_tag` = `BASE_TAG` + slot index.
- R3: A pending source whose tag equals `bc_tag` while `bc_valid` is high takes `bc_data` at that edge. Once its other source is also known, the entry is offered in the following cycle.
- R4: An entry with any pending source is never offered. A broadcast whose tag matches none of its pending sources leaves the entry pending.
- R5: A source that is allocated pending at the same edge where its producer tag is broadcast takes the broadcast value and does not miss the wakeup.
- R6: When several entries are ready, the one allocated earliest is offered first.
- R7: A younger ready entry is offered while an older entry is still waiting on an operand.
- R8: While `fu_ready` is low, the offered entry stays in the pool and stays offered. An edge with both `disp_valid` and `fu_ready` high hands the entry to the unit and frees its slot.
- R9: `full` is high exactly when every slot is occupied. An allocation request made while `full` is high creates no entry.
- R10: `alloc_tag` gives `BASE_TAG` plus the lowest free slot index, and a new instruction is placed in that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to place a new instruction |
| alloc_op | input | OP_W | Opcode of the new instruction |
| alloc_a_rdy | input | 1 | Source A value is known |
| alloc_a_val | input | DATA_W | Source A value |
| alloc_a_tag | input | TAG_W | Producer tag of source A when pending |
| alloc_b_rdy | input | 1 | Source B value is known |
| alloc_b_val | input | DATA_W | Source B value |
| alloc_b_tag | input | TAG_W | Producer tag of source B when pending |
| alloc_tag | output | TAG_W | Tag the next accepted instruction receives |
| full | output | 1 | No free slot; allocation refused |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit accepts an instruction |
| disp_valid | output | 1 | A ready entry is offered |
| disp_op | output | OP_W | Opcode of offered entry |
| disp_a | output | DATA_W | Operand A of offered entry |
| disp_b | output | DATA_W | Operand B of offered entry |
| disp_tag | output | TAG_W | Result tag of offered entry |

## Verification
All outputs are decoded from registered pool state. An allocation or broadcast sampled at an edge therefore shows up on the offer outputs right after that same edge, and a hand-off at an edge exposes the next candidate right after it. The bench drives every input one time unit after a rising edge and reads the outputs at that moment. It never reads them in the same step as an edge. The bypass scenario models a six-cycle unit: the producer's result is broadcast at the sixth edge after its hand-off, and the waiting consumer is checked just after that edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int unsigned RS_DEF_ENTRIES = 4;
    localparam int unsigned RS_DEF_DATA_W  = 16;
    localparam int unsigned RS_DEF_TAG_W   = 4;
    localparam int unsigned RS_DEF_OP_W    = 4;
    localparam int unsigned RS_NUM_SRC     = 2;
endpackage

// File: rtl/rs_src_wake.sv
module rs_src_wake #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              rdy_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    output logic              rdy_o,
    output logic [DATA_W-1:0] val_o
);
    logic hit;

    always_comb begin
        hit   = !rdy_i && bc_valid_i && (tag_i == bc_tag_i);
        rdy_o = rdy_i | hit;
        val_o = hit ? bc_data_i : val_i;
    end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
    parameter int unsigned N     = 4,
    parameter int unsigned AGE_W = 2,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            req_i,
    input  logic [N-1:0][AGE_W-1:0] age_i,
    output logic                    grant_valid_o,
    output logic [IDX_W-1:0]        grant_idx_o
);
    logic [AGE_W-1:0] best;

    always_comb begin
        grant_valid_o = 1'b0;
        grant_idx_o   = '0;
        best          = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!grant_valid_o || age_i[i] > best)) begin
                grant_valid_o = 1'b1;
                grant_idx_o   = IDX_W'(i);
                best          = age_i[i];
            end
        end
    end
endmodule

// File: rtl/rs_issue_pool.sv
module rs_issue_pool
    import rs_pkg::*;
#(
    parameter int unsigned ENTRIES  = RS_DEF_ENTRIES,
    parameter int unsigned DATA_W   = RS_DEF_DATA_W,
    parameter int unsigned TAG_W    = RS_DEF_TAG_W,
    parameter int unsigned OP_W     = RS_DEF_OP_W,
    parameter int unsigned BASE_TAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic              alloc_a_rdy,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic              alloc_b_rdy,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              fu_ready,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned AGE_W = IDX_W;
    localparam int unsigned NSRC  = RS_NUM_SRC;

    typedef struct packed {
        logic                        busy;
        logic [OP_W-1:0]             op;
        logic [NSRC-1:0]             rdy;
        logic [NSRC-1:0][DATA_W-1:0] val;
        logic [NSRC-1:0][TAG_W-1:0]  tag;
        logic [AGE_W-1:0]            age;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } pool_t;

    pool_t pool_d, pool_q;

    logic [ENTRIES-1:0]                        busy_vec;
    logic [ENTRIES-1:0]                        ready_vec;
    logic [ENTRIES-1:0][AGE_W-1:0]             age_vec;
    logic [ENTRIES-1:0][NSRC-1:0]              woke_rdy;
    logic [ENTRIES-1:0][NSRC-1:0][DATA_W-1:0]  woke_val;
    logic [NSRC-1:0]                           in_rdy, new_rdy;
    logic [NSRC-1:0][DATA_W-1:0]               in_val, new_val;
    logic [NSRC-1:0][TAG_W-1:0]                in_tag;
    logic                                      pick_v;
    logic [IDX_W-1:0]                          pick_idx;
    logic [IDX_W-1:0]                          free_idx;
    logic                                      accept, fire;

    assign in_rdy = {alloc_b_rdy, alloc_a_rdy};
    assign in_val = {alloc_b_val, alloc_a_val};
    assign in_tag = {alloc_b_tag, alloc_a_tag};

    // Wakeup compare for every stored source and for the incoming pair.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            rs_src_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wake (
                .rdy_i      (pool_q.slot[e].rdy[s]),
                .val_i      (pool_q.slot[e].val[s]),
                .tag_i      (pool_q.slot[e].tag[s]),
                .bc_valid_i (bc_valid),
                .bc_tag_i   (bc_tag),
                .bc_data_i  (bc_data),
                .rdy_o      (woke_rdy[e][s]),
                .val_o      (woke_val[e][s])
            );
        end
        assign busy_vec[e]  = pool_q.slot[e].busy;
        assign ready_vec[e] = pool_q.slot[e].busy && (&pool_q.slot[e].rdy);
        assign age_vec[e]   = pool_q.slot[e].age;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_in
        rs_src_wake #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_wake_in (
            .rdy_i      (in_rdy[s]),
            .val_i      (in_val[s]),
            .tag_i      (in_tag[s]),
            .bc_valid_i (bc_valid),
            .bc_tag_i   (bc_tag),
            .bc_data_i  (bc_data),
            .rdy_o      (new_rdy[s]),
            .val_o      (new_val[s])
        );
    end

    rs_oldest_pick #(.N(ENTRIES), .AGE_W(AGE_W)) u_pick (
        .req_i         (ready_vec),
        .age_i         (age_vec),
        .grant_valid_o (pick_v),
        .grant_idx_o   (pick_idx)
    );

    always_comb begin
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!busy_vec[e]) free_idx = IDX_W'(e);
        end
    end

    assign full      = &busy_vec;
    assign accept    = alloc_valid && !full;
    assign fire      = pick_v && fu_ready;
    assign alloc_tag = TAG_W'(BASE_TAG) + TAG_W'(free_idx);

    always_comb begin
        pool_d = pool_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (pool_q.slot[e].busy) begin
                pool_d.slot[e].rdy = woke_rdy[e];
                pool_d.slot[e].val = woke_val[e];
                pool_d.slot[e].age = pool_q.slot[e].age
                                   + AGE_W'(accept)
                                   - AGE_W'(fire && (pool_q.slot[e].age > age_vec[pick_idx]));
                if (fire && pick_idx == IDX_W'(e)) begin
                    pool_d.slot[e] = '0;
                end
            end
            if (accept && free_idx == IDX_W'(e)) begin
                pool_d.slot[e].busy = 1'b1;
                pool_d.slot[e].op   = alloc_op;
                pool_d.slot[e].rdy  = new_rdy;
                pool_d.slot[e].val  = new_val;
                pool_d.slot[e].tag  = in_tag;
                pool_d.slot[e].age  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pool_q <= '0;
        else        pool_q <= pool_d;
    end

    assign disp_valid = pick_v;
    assign disp_op    = pool_q.slot[pick_idx].op;
    assign disp_a     = pool_q.slot[pick_idx].val[0];
    assign disp_b     = pool_q.slot[pick_idx].val[1];
    assign disp_tag   = TAG_W'(BASE_TAG) + TAG_W'(pick_idx);
endmodule

// File: rtl/rs_issue_pool_chk.sv
module rs_issue_pool_chk #(
    parameter int unsigned ENTRIES  = 4,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned BASE_TAG = 4,
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_valid,
    input logic               full,
    input logic               fu_ready,
    input logic               disp_valid,
    input logic [TAG_W-1:0]   disp_tag,
    input logic [ENTRIES-1:0] busy_vec
);
    logic [IDX_W-1:0] d_idx;
    logic             handoff;

    assign d_idx   = IDX_W'(disp_tag - TAG_W'(BASE_TAG));
    assign handoff = disp_valid && fu_ready;

    AST_OCC_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !handoff) |=> ($countones(busy_vec) == $past($countones(busy_vec)) + 1)); // R10
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !handoff) |=> full); // R9
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec == '0) |-> !disp_valid); // R4
    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag >= TAG_W'(BASE_TAG)) && (disp_tag < TAG_W'(BASE_TAG + ENTRIES))); // R2
    AST_FREE_ON_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |=> !busy_vec[$past(d_idx)]); // R8
endmodule

bind rs_issue_pool rs_issue_pool_chk #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .full(full),
    .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .busy_vec(busy_vec)
);

// File: tb/sim_rs_issue_pool.sv
module sim_rs_issue_pool;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int TW = 4;
    localparam int OW = 4;
    localparam int MUL_LAT = 6;
    localparam int WD_CYCLES = 5000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alloc_valid, alloc_a_rdy, alloc_b_rdy;
    logic [OW-1:0] alloc_op;
    logic [DW-1:0] alloc_a_val, alloc_b_val;
    logic [TW-1:0] alloc_a_tag, alloc_b_tag, alloc_tag;
    logic          full, bc_valid, fu_ready, disp_valid;
    logic [TW-1:0] bc_tag, disp_tag;
    logic [DW-1:0] bc_data, disp_a, disp_b;
    logic [OW-1:0] disp_op;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_issue_pool #(.ENTRIES(4), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .BASE_TAG(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_val(alloc_a_val), .alloc_a_tag(alloc_a_tag),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_val(alloc_b_val), .alloc_b_tag(alloc_b_tag),
        .alloc_tag(alloc_tag), .full(full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [OW-1:0] op,
                       input logic ar, input logic [DW-1:0] av, input logic [TW-1:0] at,
                       input logic br, input logic [DW-1:0] bv, input logic [TW-1:0] bt);
        alloc_valid = 1'b1; alloc_op = op;
        alloc_a_rdy = ar; alloc_a_val = av; alloc_a_tag = at;
        alloc_b_rdy = br; alloc_b_val = bv; alloc_b_tag = bt;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; alloc_valid = 1'b0; bc_valid = 1'b0; fu_ready = 1'b0;
        alloc_op = '0; alloc_a_rdy = 1'b0; alloc_a_val = '0; alloc_a_tag = '0;
        alloc_b_rdy = 1'b0; alloc_b_val = '0; alloc_b_tag = '0; bc_tag = '0; bc_data = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 disp_valid", disp_valid, 0);
        chk("R1 full", full, 0);
        chk("R1 alloc_tag", alloc_tag, 4);
    endtask

    task automatic t_ready_alloc();
        fu_ready = 1'b0;
        put(4'd3, 1'b1, 16'd5, 4'd0, 1'b1, 16'd7, 4'd0);
        chk("R2 disp_valid", disp_valid, 1);
        chk("R2 disp_op", disp_op, 3);
        chk("R2 disp_a", disp_a, 5);
        chk("R2 disp_b", disp_b, 7);
        chk("R2 disp_tag", disp_tag, 4);
        tick();
        chk("R8 held while unit busy", disp_valid, 1);
        chk("R8 held tag", disp_tag, 4);
        fu_ready = 1'b1;
        tick();
        chk("R8 freed after hand-off", disp_valid, 0);
        chk("R8 slot free again", alloc_tag, 4);
        fu_ready = 1'b0;
    endtask

    task automatic t_wakeup();
        fu_ready = 1'b1;
        put(4'd1, 1'b0, 16'd0, 4'd9, 1'b1, 16'd11, 4'd0);
        chk("R4 pending not offered", disp_valid, 0);
        bc_valid = 1'b1; bc_tag = 4'd10; bc_data = 16'd99;
        tick();
        bc_valid = 1'b0;
        chk("R4 other tag ignored", disp_valid, 0);
        bc_valid = 1'b1; bc_tag = 4'd9; bc_data = 16'd33;
        tick();
        bc_valid = 1'b0;
        chk("R3 woken offered", disp_valid, 1);
        chk("R3 captured value", disp_a, 33);
        chk("R3 kept other value", disp_b, 11);
        tick();
        chk("R3 drained", disp_valid, 0);
        fu_ready = 1'b0;
    endtask

    task automatic t_same_edge();
        fu_ready = 1'b0;
        bc_valid = 1'b1; bc_tag = 4'd12; bc_data = 16'd77;
        put(4'd2, 1'b0, 16'd0, 4'd12, 1'b1, 16'd1, 4'd0);
        bc_valid = 1'b0;
        chk("R5 offered", disp_valid, 1);
        chk("R5 captured value", disp_a, 77);
        fu_ready = 1'b1;
        tick();
        chk("R5 drained", disp_valid, 0);
        fu_ready = 1'b0;
    endtask

    task automatic t_bypass();
        logic [DW-1:0] prod;
        fu_ready = 1'b0;
        put(4'd6, 1'b1, 16'd3, 4'd0, 1'b1, 16'd4, 4'd0);   // producer, slot 0
        put(4'd5, 1'b0, 16'd0, 4'd4, 1'b1, 16'd5, 4'd0);   // waits on tag 4, slot 1
        put(4'd7, 1'b1, 16'd8, 4'd0, 1'b1, 16'd9, 4'd0);   // independent, slot 2
        chk("R6 oldest ready first", disp_tag, 4);
        prod = disp_a * disp_b;
        fu_ready = 1'b1;
        tick();                                           // producer handed off
        chk("R7 younger bypasses", disp_tag, 6);
        chk("R7 bypass operand", disp_a, 8);
        chk("R10 lowest free slot", alloc_tag, 4);
        tick();
        chk("R4 consumer still waits", disp_valid, 0);
        repeat (MUL_LAT - 2) tick();
        chk("R4 waits during latency", disp_valid, 0);
        bc_valid = 1'b1; bc_tag = 4'd4; bc_data = prod;
        tick();                                           // sixth edge after hand-off
        bc_valid = 1'b0;
        chk("R3 consumer woken", disp_tag, 5);
        chk("R3 consumer operand", disp_a, 12);
        chk("R3 consumer other operand", disp_b, 5);
        tick();
        chk("R3 drained", disp_valid, 0);
        fu_ready = 1'b0;
    endtask

    task automatic t_full();
        fu_ready = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R10 alloc_tag", alloc_tag, 32'(4 + k));
            chk("R9 not full yet", full, 0);
            put(4'd1, 1'b1, 16'(10 + k), 4'd0, 1'b1, 16'd0, 4'd0);
        end
        chk("R9 full", full, 1);
        put(4'd1, 1'b1, 16'd50, 4'd0, 1'b1, 16'd0, 4'd0);
        chk("R9 still full", full, 1);
        fu_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk("R6 age order", disp_a, 32'(10 + k));
            tick();
        end
        chk("R9 refused entry absent", disp_valid, 0);
        chk("R9 full cleared", full, 0);
        fu_ready = 1'b0;
    endtask

    initial begin
        t_reset();
        t_ready_alloc();
        t_wakeup();
        t_same_edge();
        t_bypass();
        t_full();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule